// File: doc/BRIEF.md
# Reversible-Gate Ripple Carry Adder

This block adds two unsigned operands of a configurable width with a ripple carry chain in which every cell is a reversible primitive: each gate has as many outputs as inputs, and the mapping from inputs to outputs is one-to-one. The lowest bit position is a half adder made from one 3-in/3-out Peres gate. Every higher position is a full adder made from one 4-in/4-out HNG gate. Gate inputs that the addition does not use are tied to constant zero. Gate outputs that are not part of the result are brought out on a garbage bus.

The sum and the final carry serve as an ordinary adder result. The garbage bus makes every gate output visible, so a user can confirm that no information is discarded inside the structure. The width defaults to 28 bits, which gives one half adder and 27 full adders. The package gives the garbage width and the constant-input count as functions of the width. The block is purely combinational.

Top module: `rev_rca`

## Requirements
- R1: The Peres primitive maps inputs (a, b, c) to outputs p = a, q = a xor b, r = (a and b) xor c, for all 8 input combinations.
- R2: The HNG primitive maps inputs (a, b, c, d) to outputs p = a, q = b, r = a xor b xor c, s = ((a xor b) and c) xor (a and b) xor d, for all 16 input combinations.
- R3: The Peres primitive is a bijection: the 8 input combinations produce 8 distinct output triples.
- R4: The HNG primitive is a bijection: the 16 input combinations produce 16 distinct output quadruples.
- R5: Bit 0 is a half adder with no carry in. sum_o[0] = a_i[0] xor b_i[0], and bit 0 adds a_i[0] and b_i[0] into the rest of the sum as a carry of weight 2.
- R6: {carry_o, sum_o} equals a_i + b_i as an unsigned WIDTH+1 bit number for every pair of operands, including all-zero, all-one and alternating-bit operands.
- R7: The garbage bus is 2*WIDTH-1 bits wide. garb_o[0] = a_i[0]. For each position i of 1 and above, garb_o[2i-1] = a_i[i] and garb_o[2i] = b_i[i].
- R8: The package reports 2*WIDTH-1 garbage outputs and WIDTH constant inputs: one zero input per Peres gate and one per HNG gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top position |
| garb_o | output | 2*WIDTH-1 | Non-result outputs of all gates |

## Verification
All results are combinational, so each is due in the same cycle as its operands and has no register stage. The bench applies operands just after a rising edge and compares sum, carry and garbage at the following falling edge, when the ripple chain has long since settled. The primitives are driven through every input combination at the same edge spacing. Their outputs are recorded to test the formulas and to show that no output value repeats.

// File: rtl/rev_rca_pkg.sv
package rev_rca_pkg;
  function automatic int garb_width(input int width);
    return 2 * width - 1;
  endfunction

  function automatic int const_count(input int width);
    return width;
  endfunction
endpackage

// File: rtl/rsv_peres.sv
module rsv_peres (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
  assign r_o = (a_i & b_i) ^ c_i;
endmodule

// File: rtl/rsv_hng.sv
module rsv_hng (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  output logic p_o,
  output logic q_o,
  output logic r_o,
  output logic s_o
);
  logic ab_x;
  assign ab_x = a_i ^ b_i;
  assign p_o  = a_i;
  assign q_o  = b_i;
  assign r_o  = ab_x ^ c_i;
  assign s_o  = (ab_x & c_i) ^ (a_i & b_i) ^ d_i;
endmodule

// File: rtl/rsv_half_cell.sv
module rsv_half_cell (
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cout_o,
  output logic garb_o
);
  // c tied low: q is the sum, r is the carry
  rsv_peres u_peres (
    .a_i(a_i), .b_i(b_i), .c_i(1'b0),
    .p_o(garb_o), .q_o(sum_o), .r_o(cout_o)
  );
endmodule

// File: rtl/rsv_full_cell.sv
module rsv_full_cell (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       cout_o,
  output logic [1:0] garb_o
);
  // d tied low: r is the sum, s is the carry out
  rsv_hng u_hng (
    .a_i(a_i), .b_i(b_i), .c_i(cin_i), .d_i(1'b0),
    .p_o(garb_o[0]), .q_o(garb_o[1]), .r_o(sum_o), .s_o(cout_o)
  );
endmodule

// File: rtl/rev_rca.sv
module rev_rca #(
  parameter int WIDTH = 28,
  localparam int GW = rev_rca_pkg::garb_width(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic [GW-1:0]    garb_o
);
  localparam int CONST_CNT = rev_rca_pkg::const_count(WIDTH);

  logic [WIDTH:0] carry;

  rsv_half_cell u_half (
    .a_i(a_i[0]), .b_i(b_i[0]),
    .sum_o(sum_o[0]), .cout_o(carry[1]), .garb_o(garb_o[0])
  );

  for (genvar i = 1; i < WIDTH; i++) begin : g_full
    rsv_full_cell u_full (
      .a_i(a_i[i]), .b_i(b_i[i]), .cin_i(carry[i]),
      .sum_o(sum_o[i]), .cout_o(carry[i+1]),
      .garb_o(garb_o[2*i:2*i-1])
    );
  end

  assign carry[0] = 1'b0;
  assign carry_o  = carry[WIDTH];
endmodule

// File: rtl/rev_rca_chk.sv
module rev_rca_chk #(
  parameter int WIDTH = 28,
  localparam int GW = rev_rca_pkg::garb_width(WIDTH)
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic [GW-1:0]    garb_o
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    AST_SUM_EXACT: assert ({carry_o, sum_o} == ref_sum) else $error("sum mismatch"); // R6
    AST_LSB_HALF: assert (sum_o[0] == (a_i[0] ^ b_i[0])) else $error("lsb mismatch"); // R5
    AST_GARB_LSB: assert (garb_o[0] == a_i[0]) else $error("garb lsb"); // R7
    AST_NO_CARRY_ZERO: assert (!((a_i == '0 || b_i == '0) && carry_o)) else $error("carry with zero operand"); // R6
    for (int i = 1; i < WIDTH; i++) begin
      AST_GARB_PAIR: assert (garb_o[2*i-1] == a_i[i] && garb_o[2*i] == b_i[i]) else $error("garb pair"); // R7
    end
  end
endmodule

bind rev_rca rev_rca_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .carry_o(carry_o), .garb_o(garb_o)
);

// File: tb/tb_rev_rca.sv
module tb_rev_rca;
  localparam int W  = 28;
  localparam int WS = 6;
  localparam int GW  = 2 * W - 1;
  localparam int GWS = 2 * WS - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [W-1:0]  a, b, s;
  logic          co;
  logic [GW-1:0] g;
  logic [WS-1:0]  as, bs, ss;
  logic           cos;
  logic [GWS-1:0] gs;

  logic pa, pb, pc, pp, pq, pr;
  logic ha, hb, hc, hd, hp, hq, hr, hs;

  rev_rca #(.WIDTH(W)) dut (.a_i(a), .b_i(b), .sum_o(s), .carry_o(co), .garb_o(g));
  rev_rca #(.WIDTH(WS)) dut_small (.a_i(as), .b_i(bs), .sum_o(ss), .carry_o(cos), .garb_o(gs));
  rsv_peres u_pg (.a_i(pa), .b_i(pb), .c_i(pc), .p_o(pp), .q_o(pq), .r_o(pr));
  rsv_hng u_hg (.a_i(ha), .b_i(hb), .c_i(hc), .d_i(hd), .p_o(hp), .q_o(hq), .r_o(hr), .s_o(hs));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_big(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] e;
    logic [GW-1:0] eg;
    @(posedge clk); a = x; b = y;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y};
    chk("R6", {35'd0, co, s}, {35'd0, e});
    chk("R5", {63'd0, s[0]}, {63'd0, x[0] ^ y[0]});
    eg[0] = x[0];
    for (int i = 1; i < W; i++) begin
      eg[2*i-1] = x[i];
      eg[2*i]   = y[i];
    end
    chk("R7", {9'd0, g}, {9'd0, eg});
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen3[8];
    bit seen4[16];
    a = '0; b = '0; as = '0; bs = '0;
    {pa, pb, pc} = 3'b0; {ha, hb, hc, hd} = 4'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // reset-state: zero operands give zero result
    @(negedge clk);
    chk("R6", {35'd0, co, s}, 64'd0);

    // R8: structure counts
    chk("R8", GW, rev_rca_pkg::garb_width(W));
    chk("R8", $bits(g), 2 * W - 1);
    chk("R8", rev_rca_pkg::const_count(W), W);

    // R1 / R3 Peres exhaustive
    for (int v = 0; v < 8; v++) begin
      logic [2:0] o;
      logic [2:0] x;
      x = v[2:0];
      @(posedge clk); {pa, pb, pc} = x;
      @(negedge clk);
      o = {pp, pq, pr};
      chk("R1", {61'd0, o}, {61'd0, x[2], x[2] ^ x[1], (x[2] & x[1]) ^ x[0]});
      checks++;
      if (seen3[o]) begin errors++; $display("FAIL R3 actual=repeat %0h expected=distinct", o); end
      seen3[o] = 1'b1;
    end

    // R2 / R4 HNG exhaustive
    for (int v = 0; v < 16; v++) begin
      logic [3:0] o;
      logic [3:0] x;
      logic e_s;
      x = v[3:0];
      @(posedge clk); {ha, hb, hc, hd} = x;
      @(negedge clk);
      o = {hp, hq, hr, hs};
      e_s = ((x[3] ^ x[2]) & x[1]) ^ (x[3] & x[2]) ^ x[0];
      chk("R2", {60'd0, o}, {60'd0, x[3], x[2], x[3] ^ x[2] ^ x[1], e_s});
      checks++;
      if (seen4[o]) begin errors++; $display("FAIL R4 actual=repeat %0h expected=distinct", o); end
      seen4[o] = 1'b1;
    end

    // R6 / R5 / R7 exhaustive on small instance
    for (int x = 0; x < (1 << WS); x++) begin
      for (int y = 0; y < (1 << WS); y++) begin
        logic [GWS-1:0] eg;
        @(posedge clk); as = x[WS-1:0]; bs = y[WS-1:0];
        @(negedge clk);
        chk("R6", {57'd0, cos, ss}, 64'(x + y));
        chk("R5", {63'd0, ss[0]}, {63'd0, as[0] ^ bs[0]});
        eg[0] = as[0];
        for (int i = 1; i < WS; i++) begin
          eg[2*i-1] = as[i];
          eg[2*i]   = bs[i];
        end
        chk("R7", {53'd0, gs}, {53'd0, eg});
      end
    end

    // corners on default width
    chk_big('0, '0);
    chk_big('1, '0);
    chk_big('1, '1);
    chk_big('1, {{(W-1){1'b0}}, 1'b1});
    chk_big({(W/2){2'b10}}, {(W/2){2'b01}});
    chk_big({(W/2){2'b10}}, {(W/2){2'b10}});
    chk_big({(W/2){2'b01}}, {(W/2){2'b01}});
    chk_big({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}});
    for (int k = 0; k < 2000; k++) chk_big(W'($urandom), W'($urandom));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule